// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the single storage reservation that one processor core may hold for its atomic read-modify-write sequences. When the core issues a load-with-reservation, the block records the word address and marks the reservation live. A later store-conditional from the core succeeds only if that reservation is still live and names the same word. On success the block raises a write-enable in the same cycle, so the memory update goes ahead. Otherwise the write-enable stays low and the store is suppressed.

The block watches write traffic from every other bus master on a configurable number of snooped buses (two by default). Each snoop port carries a word address and a byte-enable mask. A foreign write that touches any byte of the reserved word cancels the reservation. The core is not told of the loss when it happens. It learns of it only from the reply to its next store-conditional. That reply is registered and appears one cycle after the request, with a valid strobe.

Top module: `resv_monitor`

## Requirements
- R1: After reset no reservation is held: a store-conditional issued first fails (`sc_wr_en` low, `sc_rsp_ok` low), and `sc_rsp_vld` is low until the first store-conditional.
- R2: A load-with-reservation (kind 1) records its word address and makes the reservation live. A store-conditional (kind 3) to that word then drives `sc_wr_en` high in its own cycle.
- R3: Every store-conditional clears the reservation, whether it passes or fails. A second store-conditional to the same word, with no new load-with-reservation between them, fails.
- R4: A store-conditional to a word other than the reserved one fails and still clears the reservation.
- R5: A new load-with-reservation replaces any earlier one. A store-conditional to the earlier word then fails, and one to the new word succeeds.
- R6: A plain load (kind 0) or plain store (kind 2) from the core, even to the reserved word, leaves the reservation unchanged.
- R7: On any snoop port, a valid foreign write to the reserved word with a nonzero byte-enable mask clears the reservation. Masks 4'b0001 (byte), 4'b0011 (half-word) and 4'b1111 (word) all count. Bit i of the mask selects byte i of the word.
- R8: A snooped write to a different word, or one with an all-zero byte-enable mask, leaves the reservation unchanged.
- R9: When a snooped write hits the reserved word in the same cycle as a store-conditional to that word, the snoop wins and the store-conditional fails.
- R10: `sc_rsp_vld` is high exactly in the cycle after each store-conditional request and low otherwise. `sc_rsp_ok` in that cycle equals the `sc_wr_en` value of the request cycle.
- R11: A load-with-reservation in the same cycle as a snooped write to its new word still leaves a live reservation, because the load takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_vld | input | 1 | Core request valid |
| cpu_req_kind | input | 2 | 0 load, 1 load-with-reservation, 2 store, 3 store-conditional |
| cpu_req_addr | input | ADDR_W | Core word address |
| snp_vld | input | NUM_SNOOP | Foreign write valid, one bit per snooped bus |
| snp_addr | input | NUM_SNOOP*ADDR_W | Foreign write word addresses, bus k in slice k |
| snp_be | input | NUM_SNOOP*BYTES | Foreign write byte enables, bus k in slice k |
| sc_wr_en | output | 1 | Same-cycle permission for the store-conditional memory write |
| sc_rsp_vld | output | 1 | Registered store-conditional reply strobe |
| sc_rsp_ok | output | 1 | Registered store-conditional outcome, 1 = success |

## Verification
The bench builds the block with a 4-bit word address, two snoop buses and 4-byte words. That makes the address space small enough to sweep in full. For every reserved word, every snooped word on each bus and all sixteen byte-enable masks, the bench runs a reserve, snoop, store-conditional triple, which covers every hit and miss case, including partial masks and the empty mask. Directed sequences then cover replacement, own stores and loads, back-to-back store-conditionals, and both same-cycle collisions.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    RK_LOAD      = 2'd0,
    RK_LOADRES   = 2'd1,
    RK_STORE     = 2'd2,
    RK_STORECOND = 2'd3
  } resv_kind_e;
endpackage

// File: rtl/resv_snoop_port.sv
// One snooped bus: flags a foreign write touching any byte of the held word.
module resv_snoop_port #(
  parameter int ADDR_W = 30,
  parameter int BYTES  = 4
) (
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTES-1:0]  wr_be,
  input  logic [ADDR_W-1:0] held_addr,
  output logic              hit
);
  logic word_match;
  logic any_byte;

  always_comb begin
    word_match = (wr_addr == held_addr);
    any_byte   = |wr_be;
    hit        = wr_vld & word_match & any_byte;
  end
endmodule

// File: rtl/resv_holder.sv
// Reservation address register and live flag.
module resv_holder #(
  parameter int ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] new_addr_i,
  output logic [ADDR_W-1:0] held_addr_o,
  output logic              held_vld_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q, vld_d;
  logic              addr_en;

  // a set has precedence over a clear in the same cycle
  always_comb begin
    addr_en = set_i;
    vld_d   = vld_q;
    if (set_i)      vld_d = 1'b1;
    else if (clr_i) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // address needs no reset: it is qualified by the flag
  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= new_addr_i;
  end

  assign held_addr_o = addr_q;
  assign held_vld_o  = vld_q;
endmodule

// File: rtl/resv_reply.sv
// Registered store-conditional reply.
module resv_reply (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic pass_i,
  output logic rsp_vld_o,
  output logic rsp_ok_o
);
  logic vld_q, vld_d;
  logic ok_q, ok_d;

  always_comb begin
    vld_d = fire_i;
    ok_d  = fire_i & pass_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ok_q  <= ok_d;
    end
  end

  assign rsp_vld_o = vld_q;
  assign rsp_ok_o  = ok_q;
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int ADDR_W    = 30,
  parameter int NUM_SNOOP = 2,
  parameter int BYTES     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_req_vld,
  input  logic [1:0]                  cpu_req_kind,
  input  logic [ADDR_W-1:0]           cpu_req_addr,
  input  logic [NUM_SNOOP-1:0]        snp_vld,
  input  logic [NUM_SNOOP*ADDR_W-1:0] snp_addr,
  input  logic [NUM_SNOOP*BYTES-1:0]  snp_be,
  output logic                        sc_wr_en,
  output logic                        sc_rsp_vld,
  output logic                        sc_rsp_ok
);
  import resv_pkg::*;

  resv_kind_e        kind;
  logic              is_lr, is_sc;
  logic [ADDR_W-1:0] held_addr;
  logic              held_vld;
  logic [NUM_SNOOP-1:0] bus_hit;
  logic              foreign_hit;
  logic              sc_pass;

  assign kind = resv_kind_e'(cpu_req_kind);

  always_comb begin
    is_lr = cpu_req_vld & (kind == RK_LOADRES);
    is_sc = cpu_req_vld & (kind == RK_STORECOND);
  end

  for (genvar b = 0; b < NUM_SNOOP; b++) begin : g_snoop
    resv_snoop_port #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_port (
      .wr_vld   (snp_vld[b]),
      .wr_addr  (snp_addr[b*ADDR_W +: ADDR_W]),
      .wr_be    (snp_be[b*BYTES +: BYTES]),
      .held_addr(held_addr),
      .hit      (bus_hit[b])
    );
  end

  assign foreign_hit = |bus_hit;

  // a foreign hit in the same cycle defeats the store-conditional
  always_comb begin
    sc_pass = is_sc & held_vld & (cpu_req_addr == held_addr) & ~foreign_hit;
  end

  resv_holder #(.ADDR_W(ADDR_W)) u_holder (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (is_lr),
    .clr_i      (is_sc | foreign_hit),
    .new_addr_i (cpu_req_addr),
    .held_addr_o(held_addr),
    .held_vld_o (held_vld)
  );

  resv_reply u_reply (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (is_sc),
    .pass_i   (sc_pass),
    .rsp_vld_o(sc_rsp_vld),
    .rsp_ok_o (sc_rsp_ok)
  );

  assign sc_wr_en = sc_pass;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int ADDR_W    = 30,
  parameter int NUM_SNOOP = 2,
  parameter int BYTES     = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cpu_req_vld,
  input logic [1:0]                  cpu_req_kind,
  input logic [ADDR_W-1:0]           cpu_req_addr,
  input logic [NUM_SNOOP-1:0]        snp_vld,
  input logic [NUM_SNOOP*ADDR_W-1:0] snp_addr,
  input logic [NUM_SNOOP*BYTES-1:0]  snp_be,
  input logic                        sc_wr_en,
  input logic                        sc_rsp_vld,
  input logic                        sc_rsp_ok
);
  logic sc_req;
  logic snoop_on_req;
  logic started;

  assign sc_req = cpu_req_vld && (cpu_req_kind == 2'd3);

  always_comb begin
    snoop_on_req = 1'b0;
    for (int b = 0; b < NUM_SNOOP; b++) begin
      if (snp_vld[b] && (snp_addr[b*ADDR_W +: ADDR_W] == cpu_req_addr) &&
          (snp_be[b*BYTES +: BYTES] != '0))
        snoop_on_req = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R2 / R10: the write permission only appears on a store-conditional
  a_r2_wr_only_on_sc: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr_en |-> sc_req);

  // R9: a foreign hit on the same word defeats the store-conditional
  a_r9_snoop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && snoop_on_req) |-> !sc_wr_en);

  // R10: reply strobe follows each store-conditional by one cycle
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (sc_rsp_vld == $past(sc_req)));

  // R10: reply outcome equals the write permission of the request cycle
  a_r10_rsp_ok_match: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (sc_rsp_ok == $past(sc_wr_en)));

  // R3: back-to-back store-conditionals cannot both succeed
  a_r3_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(sc_req) && sc_req) |-> !sc_wr_en);

  // R10: an ok reply always comes with its strobe
  a_r10_ok_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    sc_rsp_ok |-> sc_rsp_vld);
endmodule

bind resv_monitor resv_monitor_chk #(
  .ADDR_W(ADDR_W), .NUM_SNOOP(NUM_SNOOP), .BYTES(BYTES)
) u_chk (.*);

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
  localparam int AW = 4;
  localparam int NS = 2;
  localparam int BY = 4;

  logic              clk;
  logic              rst_n;
  logic              cpu_req_vld;
  logic [1:0]        cpu_req_kind;
  logic [AW-1:0]     cpu_req_addr;
  logic [NS-1:0]     snp_vld;
  logic [NS*AW-1:0]  snp_addr;
  logic [NS*BY-1:0]  snp_be;
  logic              sc_wr_en, sc_rsp_vld, sc_rsp_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, kept from the requirements
  bit          m_vld;
  logic [AW-1:0] m_addr;
  bit          exp_rsp_vld, exp_rsp_ok;

  resv_monitor #(.ADDR_W(AW), .NUM_SNOOP(NS), .BYTES(BY)) uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // one cycle: entered and left at a falling edge
  task automatic step(input string tag, input bit rv, input logic [1:0] k, input logic [AW-1:0] a,
                      input logic [NS-1:0] sv, input logic [NS*AW-1:0] sa, input logic [NS*BY-1:0] sb,
                      input bit chk_wr);
    bit hit;
    bit exp_wr;
    cpu_req_vld = rv; cpu_req_kind = k; cpu_req_addr = a;
    snp_vld = sv; snp_addr = sa; snp_be = sb;
    hit = 0;
    for (int b = 0; b < NS; b++)
      if (sv[b] && sa[b*AW +: AW] == m_addr && sb[b*BY +: BY] != 0) hit = 1;
    exp_wr = rv && k == 2'd3 && m_vld && a == m_addr && !hit;
    #1;
    if (chk_wr) check(tag, "sc_wr_en", sc_wr_en, exp_wr);
    @(posedge clk); #1;
    if (rv && k == 2'd1) begin m_vld = 1; m_addr = a; end
    else if ((rv && k == 2'd3) || hit) m_vld = 0;
    exp_rsp_vld = rv && k == 2'd3;
    exp_rsp_ok  = exp_wr;
    if (chk_wr) begin
      check(tag, "sc_rsp_vld", sc_rsp_vld, exp_rsp_vld);
      check(tag, "sc_rsp_ok", sc_rsp_ok, exp_rsp_ok);
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 2'd0, '0, '0, '0, '0, 1);
  endtask

  task automatic lr(input string tag, input logic [AW-1:0] a);
    step(tag, 1, 2'd1, a, '0, '0, '0, 1);
  endtask

  task automatic sc(input string tag, input logic [AW-1:0] a, input logic exp_ok);
    step(tag, 1, 2'd3, a, '0, '0, '0, 1);
    check(tag, "directed sc outcome", sc_rsp_ok, exp_ok);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cpu_req_vld = 0; cpu_req_kind = 0; cpu_req_addr = 0;
    snp_vld = 0; snp_addr = 0; snp_be = 0;
    m_vld = 0; m_addr = 0;
    repeat (3) @(negedge clk);
    check("R1", "sc_rsp_vld in reset", sc_rsp_vld, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R1");
    // R1: first store-conditional after reset fails
    sc("R1", 4'd5, 1'b0);

    // R2 then R3
    lr("R2", 4'd7);
    sc("R2", 4'd7, 1'b1);
    sc("R3", 4'd7, 1'b0);

    // R4: mismatched word fails and clears
    lr("R4", 4'd3);
    sc("R4", 4'd9, 1'b0);
    sc("R4", 4'd3, 1'b0);

    // R5: replacement
    lr("R5", 4'd1);
    lr("R5", 4'd2);
    sc("R5", 4'd1, 1'b0);
    lr("R5", 4'd1);
    lr("R5", 4'd2);
    sc("R5", 4'd2, 1'b1);

    // R6: own load and store leave it live
    lr("R6", 4'd6);
    step("R6", 1, 2'd2, 4'd6, '0, '0, '0, 1);
    step("R6", 1, 2'd0, 4'd6, '0, '0, '0, 1);
    sc("R6", 4'd6, 1'b1);

    // R9: same-cycle snoop hit on bus 1 beats the store-conditional
    lr("R9", 4'd8);
    step("R9", 1, 2'd3, 4'd8, 2'b10, {4'd8, 4'd0}, {4'b0100, 4'b0000}, 1);
    check("R9", "collision outcome", sc_rsp_ok, 1'b0);
    // R9 control: foreign hit on another word in same cycle does not disturb
    lr("R9", 4'd8);
    step("R9", 1, 2'd3, 4'd8, 2'b11, {4'd9, 4'd8}, {4'b1111, 4'b0000}, 1);
    check("R9", "non-colliding outcome", sc_rsp_ok, 1'b1);

    // R11: load-with-reservation wins over a same-cycle snoop on its word
    step("R11", 1, 2'd1, 4'd4, 2'b01, {4'd0, 4'd4}, {4'b0000, 4'b1111}, 1);
    sc("R11", 4'd4, 1'b1);

    // R10: no reply strobe for non-conditional traffic
    step("R10", 1, 2'd2, 4'd0, '0, '0, '0, 1);
    check("R10", "strobe after plain store", sc_rsp_vld, 1'b0);

    // R7 / R8 sweep: every reserved word, bus, snooped word and mask
    for (int ra = 0; ra < 16; ra++)
      for (int bus = 0; bus < NS; bus++)
        for (int sw = 0; sw < 16; sw++)
          for (int be = 0; be < 16; be++) begin
            logic [NS*AW-1:0] sa;
            logic [NS*BY-1:0] sb;
            logic [NS-1:0]    sv;
            bit exp_ok;
            string tag;
            sa = '0; sb = '0; sv = '0;
            sa[bus*AW +: AW] = sw[AW-1:0];
            sb[bus*BY +: BY] = be[BY-1:0];
            sv[bus] = 1'b1;
            exp_ok = !(sw == ra && be != 0);
            tag = exp_ok ? "R8" : "R7";
            lr(tag, ra[AW-1:0]);
            step(tag, 0, 2'd0, '0, sv, sa, sb, 1);
            step(tag, 1, 2'd3, ra[AW-1:0], '0, '0, '0, 1);
            check(tag, "sweep sc outcome", sc_rsp_ok, exp_ok);
          end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule